// File: doc/BRIEF.md
# Histogram INL Estimator for ADC Test

This block sits behind an ADC under test while a slow, linear stimulus sweeps the converter's input range. Every valid output code that the ADC produces increments a per-code occurrence counter. Once the sweep is over, a start command launches an analysis pass. Because the sweep is linear and the sample rate is constant, the running total of the bin counts up to a code stands in for that code's transition level. The pass turns these running totals into an end-point-fit integral nonlinearity figure for every code from 1 to N−1 (N = 2^CODE_W). Codes 0 and 1 do not enter the fit.

The analysis pass is a small state machine. ST_IDLE waits for start and moves to ST_SUMD. ST_SUMD walks codes 2..N−1 to form the denominator D, then moves to ST_CHK. ST_CHK goes to ST_ERR when D is zero and to ST_FEED otherwise. ST_FEED adds the current bin to the running numerator sum and launches one division, then moves to ST_WAIT. ST_WAIT holds until the divider finishes, emits the result, and returns to ST_FEED, or moves to ST_DONE after code N−1. A start in ST_IDLE, ST_DONE or ST_ERR begins a new pass. A clear in any state zeroes the bins and forces ST_IDLE.

Each result is a signed fixed-point value with 8 fractional bits and comes with a one-cycle valid pulse. A running largest magnitude gives the overall INL once done is high.

Top module: `hist_inl_est`

## Requirements
- R1: While the state is ST_IDLE, ST_DONE or ST_ERR and clr is low, each cycle with smp_vld high adds one to the bin of smp_code. Samples presented during ST_SUMD, ST_CHK, ST_FEED or ST_WAIT are not counted.
- R2: A bin that holds 2^CNT_W−1 stays at that value on further samples of its code.
- R3: clr zeroes every bin, drops done and err, and returns the machine to ST_IDLE.
- R4: After start, results appear in ascending code order 1, 2, …, N−1. There is exactly one inl_vld pulse per code and two pulses are never in adjacent cycles.
- R5: For code k the value on inl_val is floor(C_k·(N−2)·256 / D) − (k−1)·256, in two's complement with 8 fractional bits. Here C_k is the sum of bins 2..k (zero for k=1), and D is the sum of bins 2..N−1. Bins 0 and 1 therefore have no effect.
- R6: The results for code 1 and code N−1 are exactly zero.
- R7: When done is high, max_abs equals the largest |inl_val| of the pass, in the same format.
- R8: done rises together with the code N−1 pulse and stays high until start or clr.
- R9: If D is zero, err rises, no result is emitted, done stays low, and err holds until start or clr.
- R10: After reset all outputs are zero and every bin is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero all bins and return to idle |
| smp_vld | input | 1 | ADC code strobe |
| smp_code | input | CODE_W | ADC output code |
| start | input | 1 | Begin an analysis pass |
| inl_vld | output | 1 | One-cycle result strobe |
| inl_code | output | CODE_W | Code of the current result |
| inl_val | output | CODE_W+9 | Signed INL, 8 fractional bits |
| max_abs | output | CODE_W+9 | Largest result magnitude of the pass |
| done | output | 1 | Pass complete |
| err | output | 1 | Denominator was zero |

## Verification
A corrupted bin or a wrong running sum shows up as a wrong inl_val at the first code whose cumulative sum includes it. The end codes act as a cross-check: a denominator that disagrees with the final numerator makes the code N−1 result nonzero. A slip in the state sequence shows at once as out-of-order inl_code, as back-to-back pulses, or as a pass that emits fewer than N−1 results before done. A counter that wraps or that counts during a pass shows up in the following pass's values.

// File: rtl/hist_inl_pkg.sv
package hist_inl_pkg;
    localparam int FRAC_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUMD,
        ST_CHK,
        ST_FEED,
        ST_WAIT,
        ST_DONE,
        ST_ERR
    } est_state_t;
endpackage

// File: rtl/hist_bin_bank.sv
module hist_bin_bank #(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc_en,
    input  logic [CODE_W-1:0] inc_code,
    input  logic [CODE_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_cnt
);
    localparam int NBINS = 1 << CODE_W;

    logic [CNT_W-1:0] cnt_q [NBINS];

    for (genvar g = 0; g < NBINS; g++) begin : g_bin
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cnt_q[g] <= '0;
            end else if (inc_en && inc_code == CODE_W'(g) && cnt_q[g] != '1) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end
    end

    assign rd_cnt = cnt_q[rd_addr];
endmodule

// File: rtl/seq_restoring_div.sv
module seq_restoring_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             fin,
    output logic [NUM_W-1:0] quo
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem_q;
    logic [DEN_W-1:0]  den_q;
    logic [NUM_W-1:0]  quo_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              fin_q;
    logic [DEN_W:0]    trial;
    logic [DEN_W:0]    diff;

    assign trial = {rem_q, quo_q[NUM_W-1]};
    assign diff  = trial - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            quo_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                den_q  <= den;
                quo_q  <= num;
                step_q <= STEP_W'(NUM_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                if (trial >= {1'b0, den_q}) begin
                    rem_q <= diff[DEN_W-1:0];
                    quo_q <= {quo_q[NUM_W-2:0], 1'b1};
                end else begin
                    rem_q <= trial[DEN_W-1:0];
                    quo_q <= {quo_q[NUM_W-2:0], 1'b0};
                end
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin = fin_q;
    assign quo = quo_q;
endmodule

// File: rtl/hist_inl_est.sv
module hist_inl_est
    import hist_inl_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int CNT_W  = 8,
    localparam int OUT_W = CODE_W + FRAC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    smp_vld,
    input  logic [CODE_W-1:0]       smp_code,
    input  logic                    start,
    output logic                    inl_vld,
    output logic [CODE_W-1:0]       inl_code,
    output logic signed [OUT_W-1:0] inl_val,
    output logic [OUT_W-1:0]        max_abs,
    output logic                    done,
    output logic                    err
);
    localparam int NBINS = 1 << CODE_W;
    localparam int ACC_W = CNT_W + CODE_W;
    localparam int NUM_W = ACC_W + CODE_W + FRAC_W;
    localparam int QW    = CODE_W + FRAC_W;
    localparam logic [CODE_W-1:0] LAST = CODE_W'(NBINS - 1);

    est_state_t st_q, st_nxt;

    logic [CODE_W-1:0] idx_q;
    logic [ACC_W-1:0]  acc_d_q, acc_c_q, c_next;
    logic [CNT_W-1:0]  rd_cnt;
    logic              idle_like, inc_en, div_go, div_fin;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [CODE_W-1:0] idx_m1;
    logic signed [OUT_W-1:0] q_part, off_part, inl_new;
    logic [OUT_W-1:0]  mag_new;

    assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE) || (st_q == ST_ERR);
    assign inc_en    = smp_vld && idle_like && !clr;

    hist_bin_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W)) bins_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc_en(inc_en),
        .inc_code(smp_code), .rd_addr(idx_q), .rd_cnt(rd_cnt)
    );

    // bins 0 and 1 are left out of every sum
    assign c_next  = (idx_q >= CODE_W'(2)) ? acc_c_q + ACC_W'(rd_cnt) : acc_c_q;
    assign div_num = (NUM_W'(c_next) * NUM_W'(NBINS - 2)) << FRAC_W;
    assign div_go  = (st_q == ST_FEED);

    seq_restoring_div #(.NUM_W(NUM_W), .DEN_W(ACC_W)) div_i (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num),
        .den(acc_d_q), .fin(div_fin), .quo(div_quo)
    );

    assign idx_m1   = idx_q - 1'b1;
    assign q_part   = $signed({1'b0, div_quo[QW-1:0]});
    assign off_part = $signed({1'b0, idx_m1, {FRAC_W{1'b0}}});
    assign inl_new  = q_part - off_part;
    assign mag_new  = inl_new[OUT_W-1] ? OUT_W'(-inl_new) : OUT_W'(inl_new);

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE, ST_DONE, ST_ERR: if (start) st_nxt = ST_SUMD;
            ST_SUMD: if (idx_q == LAST) st_nxt = ST_CHK;
            ST_CHK:  st_nxt = (acc_d_q == '0) ? ST_ERR : ST_FEED;
            ST_FEED: st_nxt = ST_WAIT;
            ST_WAIT: if (div_fin) st_nxt = (idx_q == LAST) ? ST_DONE : ST_FEED;
            default: st_nxt = ST_IDLE;
        endcase
        if (clr) st_nxt = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            acc_d_q  <= '0;
            acc_c_q  <= '0;
            inl_vld  <= 1'b0;
            inl_code <= '0;
            inl_val  <= '0;
            max_abs  <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            inl_vld <= 1'b0;
            if (clr) begin
                done <= 1'b0;
                err  <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_IDLE, ST_DONE, ST_ERR: if (start) begin
                        idx_q   <= CODE_W'(2);
                        acc_d_q <= '0;
                        max_abs <= '0;
                        done    <= 1'b0;
                        err     <= 1'b0;
                    end
                    ST_SUMD: begin
                        acc_d_q <= acc_d_q + ACC_W'(rd_cnt);
                        idx_q   <= idx_q + 1'b1;
                    end
                    ST_CHK: begin
                        idx_q   <= CODE_W'(1);
                        acc_c_q <= '0;
                        if (acc_d_q == '0) err <= 1'b1;
                    end
                    ST_FEED: acc_c_q <= c_next;
                    ST_WAIT: if (div_fin) begin
                        inl_vld  <= 1'b1;
                        inl_code <= idx_q;
                        inl_val  <= inl_new;
                        if (mag_new > max_abs) max_abs <= mag_new;
                        if (idx_q == LAST) done <= 1'b1;
                        else               idx_q <= idx_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/hist_inl_chk.sv
module hist_inl_chk #(
    parameter int CODE_W = 4,
    parameter int OUT_W  = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    clr,
    input logic                    start,
    input logic                    inl_vld,
    input logic [CODE_W-1:0]       inl_code,
    input logic signed [OUT_W-1:0] inl_val,
    input logic [OUT_W-1:0]        max_abs,
    input logic                    done,
    input logic                    err
);
    localparam logic [CODE_W-1:0] LAST = '1;

    logic [OUT_W-1:0] mag;
    assign mag = inl_val[OUT_W-1] ? OUT_W'(-inl_val) : OUT_W'(inl_val);

    AST_ENDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        inl_vld && (inl_code == CODE_W'(1) || inl_code == LAST) |-> inl_val == '0); // R6
    AST_PULSE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        inl_vld |=> !inl_vld); // R4
    AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        inl_vld |-> inl_code != '0); // R4
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !inl_vld && !done); // R9
    AST_MAX_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        inl_vld && !start && !clr |=> max_abs >= $past(mag)); // R7
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start && !clr |=> done); // R8
endmodule

bind hist_inl_est hist_inl_chk #(.CODE_W(CODE_W), .OUT_W(OUT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .inl_vld(inl_vld),
    .inl_code(inl_code), .inl_val(inl_val), .max_abs(max_abs),
    .done(done), .err(err)
);

// File: tb/hist_inl_est_tb_top.sv
module hist_inl_est_tb_top;
    localparam int CW   = 4;
    localparam int NB   = 16;
    localparam int CNTW = 8;
    localparam int OW   = CW + 9;
    localparam int SATV = (1 << CNTW) - 1;
    localparam int SCEN = 3;
    // per-scenario bin contents for codes 0..15
    localparam int HIST [SCEN][NB] = '{
        '{4, 4, 4, 4, 4, 4, 4, 4, 4, 4, 4, 4, 4, 4, 4, 4},
        '{2, 5, 1, 3, 6, 2, 4, 8, 1, 3, 5, 2, 7, 4, 3, 9},
        '{9, 7, 3, 0, 10, 2, 0, 0, 12, 1, 0, 6, 0, 0, 2, 5}
    };

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, clr = 1'b0, smp_vld = 1'b0, start = 1'b0;
    logic [CW-1:0] smp_code = '0;
    logic inl_vld, done, err;
    logic [CW-1:0] inl_code;
    logic signed [OW-1:0] inl_val;
    logic [OW-1:0] max_abs;

    hist_inl_est #(.CODE_W(CW), .CNT_W(CNTW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .smp_vld(smp_vld),
        .smp_code(smp_code), .start(start), .inl_vld(inl_vld),
        .inl_code(inl_code), .inl_val(inl_val), .max_abs(max_abs),
        .done(done), .err(err)
    );

    int checks = 0, fails = 0;
    int model [NB];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input int c);
        smp_vld  = 1'b1;
        smp_code = CW'(c);
        @(negedge clk);
        smp_vld = 1'b0;
        if (model[c] < SATV) model[c]++;
    endtask

    task automatic clear_all();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < NB; i++) model[i] = 0;
    endtask

    task automatic run_pass(input bit inject, input bit exp_err);
        int d, nexp, mx, got, cyc, c, e, v;
        d = 0;
        for (int i = 2; i < NB; i++) d += model[i];
        nexp = 1; mx = 0; got = 0; cyc = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (cyc < 5000) begin
            // R1: samples offered while the pass is running must be ignored
            smp_vld  = inject && cyc >= 1 && cyc < 7;
            smp_code = CW'(7);
            @(negedge clk);
            cyc++;
            if (inl_vld) begin
                got++;
                if (d > 0) begin
                    c = 0;
                    for (int i = 2; i <= int'(inl_code); i++) c += model[i];
                    e = (c * (NB - 2) * 256) / d - (int'(inl_code) - 1) * 256;
                    v = int'(inl_val);
                    chk(int'(inl_code) == nexp, "R4 order", int'(inl_code), nexp);
                    chk(v == e, "R5 value", v, e);
                    if (inl_code == CW'(1) || inl_code == CW'(NB - 1))
                        chk(v == 0, "R6 end zero", v, 0);
                    if ((v < 0 ? -v : v) > mx) mx = (v < 0 ? -v : v);
                    nexp++;
                end
            end
            if (done || err) break;
        end
        smp_vld = 1'b0;
        if (exp_err) begin
            chk(err == 1'b1, "R9 err", int'(err), 1);
            chk(got == 0, "R9 no output", got, 0);
            chk(done == 1'b0, "R9 no done", int'(done), 0);
        end else begin
            chk(done == 1'b1, "R8 done", int'(done), 1);
            chk(got == NB - 1, "R4 count", got, NB - 1);
            chk(int'(max_abs) == mx, "R7 max", int'(max_abs), mx);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(inl_vld == 1'b0, "R10 vld", int'(inl_vld), 0);
        chk(done == 1'b0, "R10 done", int'(done), 0);
        chk(err == 1'b0, "R10 err", int'(err), 0);
        chk(max_abs == '0, "R10 max", int'(max_abs), 0);
        run_pass(1'b0, 1'b1); // R10 bins empty -> zero denominator

        for (int s = 0; s < SCEN; s++) begin
            clear_all();
            chk(err == 1'b0 && done == 1'b0, "R3 flags cleared", int'(err) + int'(done), 0);
            for (int k = 0; k < NB; k++)
                for (int r = 0; r < HIST[s][k]; r++) put(k);
            run_pass(s == 1, 1'b0);
            if (s == 1) run_pass(1'b0, 1'b0); // R1 injected samples not counted
        end

        // R8 done holds
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R8 hold", int'(done), 1);
        // R1 samples while done are counted
        put(9); put(9); put(3);
        run_pass(1'b0, 1'b0);

        // R2 saturation
        clear_all();
        for (int k = 0; k < NB; k++) put(k);
        for (int r = 0; r < 300; r++) put(5);
        run_pass(1'b0, 1'b0);

        // R9 only codes 0 and 1 present
        clear_all();
        for (int r = 0; r < 3; r++) begin put(0); put(1); end
        run_pass(1'b0, 1'b1);
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R9 err holds", int'(err), 1);

        // R3 clear after a good pass
        for (int k = 2; k < NB; k++) put(k);
        run_pass(1'b0, 1'b0);
        clear_all();
        chk(done == 1'b0, "R3 done dropped", int'(done), 0);
        run_pass(1'b0, 1'b1); // R3 bins emptied

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule